// File: doc/BRIEF.md
# Extended-Precision Floating-Point Comparator

This block compares two 80-bit extended-precision floating-point values and returns a relation code. Each operand has a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is an explicit integer bit. The relation code is built so that a host core can copy C0, C2 and C3 into its carry, parity and zero flags. The host can then use unsigned-style branches (above, below, equal) on the result, and a set parity flag tells it that the result is unordered. Along with the relation, the block reports an invalid-operation flag and a denormal-operand flag.

A caller presents operands `a_i` and `b_i` with a two-bit mode and pulses `valid_i`. One cycle later the result appears together with `valid_o`. The result then holds until the next strobe.

There are three behaviours:
- **Ordered compare:** any NaN operand is an invalid operation.
- **Unordered compare:** only a signaling NaN is an invalid operation.
- **Zero test:** `a_i` is checked against +0.0 and `b_i` is disregarded.

In every mode, zeros of opposite sign compare equal.

Top module: `xfp_compare`

## Requirements
- R1: Operand classes are decoded from the fields: bit 79 sign, bits 78:64 exponent, bits 63:0 significand (bit 63 the integer bit). The classes are:
  - NaN: exponent all ones and significand bits 62:0 nonzero.
  - Quiet NaN: a NaN with bit 62 set. Signaling NaN: a NaN with bit 62 clear.
  - Infinity: exponent all ones and bits 62:0 zero.
  - Zero: exponent zero and significand zero.
  - Denormal: exponent zero and significand nonzero.
- R2: `cc_o` bit 0 is C0, bit 1 is C1, bit 2 is C2 and bit 3 is C3. {C3,C2,C0} encodes the relation: a greater than b is 000, a less than b is 001, a equal to b is 100.
- R3: When either compared operand is a NaN, the relation is unordered, {C3,C2,C0} = 111.
- R4: C1 (`cc_o[1]`) is zero after every compare.
- R5: Non-NaN operands are ordered first by sign and then by the unsigned magnitude {exponent, significand}. A larger magnitude is greater for positive operands and smaller for negative ones, so infinities lie beyond every finite value.
- R6: +0.0 and -0.0 compare equal in every mode.
- R7: In ordered mode (`mode_i` = 0, and also the spare code 3), a quiet or signaling NaN in either operand sets `invalid_o`. Otherwise `invalid_o` is cleared.
- R8: In unordered mode (`mode_i` = 1), `invalid_o` is set only when either operand is a signaling NaN. A quiet NaN leaves it clear.
- R9: In zero-test mode (`mode_i` = 2), `b_i` has no effect. The result and flags equal an ordered compare of `a_i` against +0.0.
- R10: `denormal_o` is set when any compared operand is denormal; in zero-test mode this means `a_i` only. Otherwise it is cleared.
- R11: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. Results and flags change only then and hold otherwise.
- R12: While reset is high, `valid_o`, `cc_o`, `invalid_o` and `denormal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operand strobe |
| mode_i | input | 2 | 0 ordered, 1 unordered, 2 zero test, 3 ordered |
| a_i | input | 80 | First operand |
| b_i | input | 80 | Second operand |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| cc_o | output | 4 | {C3,C2,C1,C0} condition bits |
| invalid_o | output | 1 | Invalid-operation flag |
| denormal_o | output | 1 | Denormal-operand flag |

## Verification
Several results can be due in the same cycle: an unordered relation, a raised or suppressed invalid flag, and a denormal flag. The bench provokes this by pairing NaNs of both kinds with denormal operands in each mode. It judges every field of the registered result against an independent reference model on each clock. Directed sequences cover signed zeros, infinities and zero-test calls whose `b_i` holds a NaN or a denormal. A random stream with gaps in `valid_i` then checks that the outputs hold between strobes.

// File: rtl/xfp_cmp_pkg.sv
package xfp_cmp_pkg;

  parameter int XFP_EXP_W = 15;
  parameter int XFP_SIG_W = 64;

  typedef enum logic [1:0] {
    MODE_ORD   = 2'd0,
    MODE_UNORD = 2'd1,
    MODE_ZTEST = 2'd2,
    MODE_SPARE = 2'd3
  } cmp_mode_e;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } cmp_rel_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic qnan;
    logic snan;
    logic inf;
    logic zero;
    logic den;
  } op_class_t;

endpackage

// File: rtl/xfp_classify.sv
module xfp_classify
  import xfp_cmp_pkg::*;
#(
  parameter int EXP_W = XFP_EXP_W,
  parameter int SIG_W = XFP_SIG_W,
  localparam int TOT_W = 1 + EXP_W + SIG_W,
  localparam int MAG_W = EXP_W + SIG_W
) (
  input  logic [TOT_W-1:0] val,
  output op_class_t        cls,
  output logic [MAG_W-1:0] mag
);
  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             exp_max, exp_zero, frac_nz;

  assign exp_f    = val[TOT_W-2 -: EXP_W];
  assign sig_f    = val[SIG_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_zero = ~|exp_f;
  // fraction bits exclude the explicit integer bit
  assign frac_nz  = |sig_f[SIG_W-2:0];

  always_comb begin
    cls.sign = val[TOT_W-1];
    cls.nan  = exp_max & frac_nz;
    cls.qnan = cls.nan & sig_f[SIG_W-2];
    cls.snan = cls.nan & ~sig_f[SIG_W-2];
    cls.inf  = exp_max & ~frac_nz;
    cls.zero = exp_zero & ~|sig_f;
    cls.den  = exp_zero & |sig_f;
  end

  assign mag = val[MAG_W-1:0];
endmodule

// File: rtl/xfp_relate.sv
module xfp_relate
  import xfp_cmp_pkg::*;
#(
  parameter int MAG_W = XFP_EXP_W + XFP_SIG_W
) (
  input  op_class_t        cls_a,
  input  op_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output cmp_rel_e         rel
);
  logic mag_gt, mag_eq;

  assign mag_gt = mag_a > mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    if (cls_a.nan || cls_b.nan)
      rel = REL_UN;
    else if (cls_a.zero && cls_b.zero)
      rel = REL_EQ;                       // signed zeros are equal
    else if (cls_a.sign != cls_b.sign)
      rel = cls_a.sign ? REL_LT : REL_GT;
    else if (mag_eq)
      rel = REL_EQ;
    else if (mag_gt ^ cls_a.sign)
      rel = REL_GT;
    else
      rel = REL_LT;
  end
endmodule

// File: rtl/xfp_compare.sv
module xfp_compare
  import xfp_cmp_pkg::*;
#(
  parameter int EXP_W = XFP_EXP_W,
  parameter int SIG_W = XFP_SIG_W,
  localparam int TOT_W = 1 + EXP_W + SIG_W,
  localparam int MAG_W = EXP_W + SIG_W,
  localparam int N_OPS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [1:0]       mode_i,
  input  logic [TOT_W-1:0] a_i,
  input  logic [TOT_W-1:0] b_i,
  output logic             valid_o,
  output logic [3:0]       cc_o,
  output logic             invalid_o,
  output logic             denormal_o
);
  cmp_mode_e        mode;
  logic [TOT_W-1:0] ops [N_OPS];
  op_class_t        cls [N_OPS];
  logic [MAG_W-1:0] mag [N_OPS];
  cmp_rel_e         rel;
  logic             inv_c, den_c;
  logic [3:0]       cc_c;

  assign mode   = cmp_mode_e'(mode_i);
  assign ops[0] = a_i;
  // zero test: second operand forced to +0.0
  assign ops[1] = (mode == MODE_ZTEST) ? '0 : b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    xfp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .val (ops[g]),
      .cls (cls[g]),
      .mag (mag[g])
    );
  end

  xfp_relate #(.MAG_W(MAG_W)) u_rel (
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .mag_a (mag[0]),
    .mag_b (mag[1]),
    .rel   (rel)
  );

  always_comb begin
    if (mode == MODE_UNORD)
      inv_c = cls[0].snan | cls[1].snan;
    else
      inv_c = cls[0].nan | cls[1].nan;
    den_c = cls[0].den | cls[1].den;
  end

  // {C3,C2,C1,C0}; C1 always cleared
  always_comb begin
    unique case (rel)
      REL_GT:  cc_c = 4'b0000;
      REL_LT:  cc_c = 4'b0001;
      REL_EQ:  cc_c = 4'b1000;
      default: cc_c = 4'b1101;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o    <= 1'b0;
      cc_o       <= 4'b0000;
      invalid_o  <= 1'b0;
      denormal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cc_o       <= cc_c;
        invalid_o  <= inv_c;
        denormal_o <= den_c;
      end
    end
  end

  a_r3_nan_unordered: assert property (@(posedge clk) disable iff (rst)
    valid_i && (cls[0].nan || cls[1].nan) |=> cc_o[3] && cc_o[2] && cc_o[0]);

  a_r4_c1_clear: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !cc_o[1]);

  a_r6_zero_eq: assert property (@(posedge clk) disable iff (rst)
    valid_i && cls[0].zero && cls[1].zero |=> cc_o == 4'b1000);

  a_r7_ord_invalid: assert property (@(posedge clk) disable iff (rst)
    valid_i && mode_i != 2'd1 && (cls[0].nan || cls[1].nan) |=> invalid_o);

  a_r8_quiet_no_invalid: assert property (@(posedge clk) disable iff (rst)
    valid_i && mode_i == 2'd1 && !cls[0].snan && !cls[1].snan |=> !invalid_o);

  a_r10_denormal: assert property (@(posedge clk) disable iff (rst)
    valid_i && (cls[0].den || cls[1].den) |=> denormal_o);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o && $stable(cc_o) && $stable(invalid_o) && $stable(denormal_o));

endmodule

// File: tb/tb_xfp_compare.sv
module tb_xfp_compare;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  mode_i;
  logic [79:0] a_i, b_i;
  logic        valid_o;
  logic [3:0]  cc_o;
  logic        invalid_o, denormal_o;

  int checks = 0;
  int errors = 0;

  // expected registered state
  logic       e_valid;
  logic [3:0] e_cc;
  logic       e_inv, e_den;
  string      e_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfp_compare dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .cc_o(cc_o),
    .invalid_o(invalid_o), .denormal_o(denormal_o)
  );

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  // reference: returns {cc[3:0], inv, den}
  function automatic logic [5:0] ref_cmp(input logic [79:0] a, input logic [79:0] b, input logic [1:0] m);
    logic an, bn, asn, bsn, az, bz, ad, bd, un, inv, gt, eq;
    logic [3:0] cc;
    if (m == 2'd2) b = '0;
    an  = (a[78:64] == 15'h7fff) && (a[62:0] != 0);
    bn  = (b[78:64] == 15'h7fff) && (b[62:0] != 0);
    asn = an && !a[62];
    bsn = bn && !b[62];
    az  = a[78:0] == 0;
    bz  = b[78:0] == 0;
    ad  = (a[78:64] == 0) && (a[63:0] != 0);
    bd  = (b[78:64] == 0) && (b[63:0] != 0);
    un  = an || bn;
    inv = (m == 2'd1) ? (asn || bsn) : un;
    gt = 1'b0; eq = 1'b0;
    if (!un) begin
      if (az && bz) eq = 1'b1;
      else if (a[79] != b[79]) gt = !a[79];
      else if (a[78:0] == b[78:0]) eq = 1'b1;
      else gt = a[79] ? (a[78:0] < b[78:0]) : (a[78:0] > b[78:0]);
    end
    if (un)      cc = 4'b1101;
    else if (eq) cc = 4'b1000;
    else if (gt) cc = 4'b0000;
    else         cc = 4'b0001;
    return {cc, inv, den_sel(ad, bd)};
  endfunction

  function automatic logic den_sel(input logic x, input logic y);
    return x || y;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic compare_outputs();
    chk(e_req, {7'd0, valid_o},    {7'd0, e_valid}, "valid_o (R11)");
    chk(e_req, {4'd0, cc_o},       {4'd0, e_cc},    "cc_o");
    chk(e_req, {7'd0, invalid_o},  {7'd0, e_inv},   "invalid_o");
    chk(e_req, {7'd0, denormal_o}, {7'd0, e_den},   "denormal_o");
  endtask

  // one cycle: check previous result, then drive next stimulus
  task automatic step(input logic v, input logic [1:0] m, input logic [79:0] a,
                      input logic [79:0] b, input string req);
    logic [5:0] r;
    @(negedge clk);
    compare_outputs();
    valid_i = v; mode_i = m; a_i = a; b_i = b;
    e_valid = v;
    if (v) begin
      r = ref_cmp(a, b, m);
      e_cc = r[5:2]; e_inv = r[1]; e_den = r[0]; e_req = req;
    end
  endtask

  logic [79:0] pool [14];

  initial begin
    pool[0]  = mk(0, 15'h0000, 64'h0);                  // +0
    pool[1]  = mk(1, 15'h0000, 64'h0);                  // -0
    pool[2]  = mk(0, 15'h3fff, 64'h8000_0000_0000_0000); // +1
    pool[3]  = mk(1, 15'h3fff, 64'h8000_0000_0000_0000); // -1
    pool[4]  = mk(0, 15'h4000, 64'h8000_0000_0000_0000); // +2
    pool[5]  = mk(1, 15'h4000, 64'hc000_0000_0000_0000); // -3
    pool[6]  = mk(0, 15'h0000, 64'h0000_0000_0000_0001); // +denormal
    pool[7]  = mk(1, 15'h0000, 64'h0000_0000_0000_0100); // -denormal
    pool[8]  = mk(0, 15'h7fff, 64'h8000_0000_0000_0000); // +inf
    pool[9]  = mk(1, 15'h7fff, 64'h8000_0000_0000_0000); // -inf
    pool[10] = mk(0, 15'h7fff, 64'hc000_0000_0000_0000); // qNaN
    pool[11] = mk(1, 15'h7fff, 64'h8000_0000_0000_0001); // sNaN
    pool[12] = mk(0, 15'h7ffe, 64'hffff_ffff_ffff_ffff); // max finite
    pool[13] = mk(0, 15'h3fff, 64'h8000_0000_0000_0001); // just above 1
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; mode_i = 2'd0; a_i = '0; b_i = '0;
    e_valid = 1'b0; e_cc = 4'd0; e_inv = 1'b0; e_den = 1'b0; e_req = "R12";
    repeat (3) @(posedge clk);
    // R12: reset state while reset still high
    @(negedge clk);
    compare_outputs();
    rst = 1'b0;

    // R2 R5: basic ordering
    step(1, 2'd0, pool[4],  pool[2],  "R2");
    step(1, 2'd0, pool[2],  pool[4],  "R2");
    step(1, 2'd0, pool[2],  pool[2],  "R2");
    step(1, 2'd0, pool[3],  pool[5],  "R5");
    step(1, 2'd0, pool[5],  pool[3],  "R5");
    step(1, 2'd0, pool[8],  pool[12], "R5");
    step(1, 2'd0, pool[9],  pool[5],  "R5");
    step(1, 2'd0, pool[13], pool[2],  "R5");
    step(1, 2'd0, pool[1],  pool[6],  "R5");
    // R6: signed zeros in all modes
    step(1, 2'd0, pool[1],  pool[0],  "R6");
    step(1, 2'd1, pool[0],  pool[1],  "R6");
    step(1, 2'd2, pool[1],  pool[4],  "R6");
    step(1, 2'd3, pool[1],  pool[1],  "R6");
    // R3 R7 R8: NaNs, combined with denormals (R10)
    step(1, 2'd0, pool[10], pool[2],  "R7");
    step(1, 2'd3, pool[2],  pool[11], "R7");
    step(1, 2'd1, pool[10], pool[6],  "R8");
    step(1, 2'd1, pool[7],  pool[11], "R8");
    step(1, 2'd1, pool[10], pool[10], "R3");
    step(1, 2'd0, pool[6],  pool[10], "R10");
    // R9: b ignored in zero test
    step(1, 2'd2, pool[3],  pool[11], "R9");
    step(1, 2'd2, pool[4],  pool[6],  "R9");
    step(1, 2'd2, pool[6],  pool[10], "R9");
    step(1, 2'd2, pool[10], pool[2],  "R9");
    step(1, 2'd2, pool[0],  pool[9],  "R9");
    // R11: hold across idle cycles with junk inputs
    step(0, 2'd0, pool[11], pool[10], "R11");
    step(0, 2'd1, pool[6],  pool[3],  "R11");
    step(1, 2'd0, pool[7],  pool[6],  "R10");
    step(0, 2'd2, pool[9],  pool[9],  "R11");
    // random mix, R1 R4 covered by every compare
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 2'($urandom % 4), pool[$urandom % 14],
           pool[$urandom % 14], "R1 R4");
    end
    step(0, 2'd0, '0, '0, "R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule